// File: doc/BRIEF.md
# Interleaved Cache-Block Beat Sequencer

This block produces the order in which the eight quadwords of a 64-byte cache block are moved across a system data port. A requester hands it the index of the critical quadword (address bits [5:3]) and a mode bit. The block then emits one quadword index per accepted beat until the whole block has been covered. It marks the first and last beats, and it raises a one-cycle completion pulse after the final beat is taken.

Two orderings exist. In single-pumped mode each beat's index is the beat number XORed with the critical index, so the critical quadword always leads. In double-pumped mode quadwords travel as aligned pairs (octawords). Only the pair-select bits are XOR-interleaved with the starting pair. The low bit simply walks 0 then 1 inside each pair. The block carries no data. A downstream data path uses the index and flags to steer the quadwords.

Top module: `qw_wrap_sequencer`

## Requirements
- R1: After reset, startReady is 1, beatValid is 0 and done is 0.
- R2: With startDouble=0, the beat numbered k (k = 0..7, counting accepted beats) carries beatIdx = k XOR startIdx, where beatIdx bit 2 is address bit 5 and bit 0 is address bit 3. The first beat therefore equals startIdx.
- R3: With startDouble=1, beats 2j and 2j+1 both carry beatIdx[2:1] = j XOR startIdx[2:1].
- R4: With startDouble=1, beatIdx[0] is 0 on even-numbered beats and 1 on odd-numbered beats, whatever startIdx[0] is.
- R5: Each transfer has exactly eight accepted beats. beatFirst is 1 only on beat 0, and beatLast is 1 only on beat 7.
- R6: While a transfer is in progress, startReady is 0, and a startValid pulse has no effect on the beats being sent.
- R7: While beatValid is 1 and beatReady is 0, beatIdx, beatFirst and beatLast hold their values.
- R8: done is 1 for exactly one cycle, the cycle after the beat with beatLast is accepted. In that cycle beatValid is 0 and startReady is 1 again.
- R9: A start is taken on a clock edge where startValid and startReady are both 1. beatValid rises in the next cycle, and the mode and index are captured at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request present |
| startReady | output | 1 | Sequencer idle and able to take a start |
| startIdx | input | 3 | Critical quadword index, address bits [5:3] |
| startDouble | input | 1 | 1 selects paired (double-pumped) ordering |
| beatValid | output | 1 | A beat index is offered |
| beatReady | input | 1 | Consumer takes the offered beat |
| beatIdx | output | 3 | Quadword index of the current beat |
| beatFirst | output | 1 | Current beat is the first of the block |
| beatLast | output | 1 | Current beat is the last of the block |
| done | output | 1 | One-cycle pulse after the last beat is taken |

## Verification
The bench builds the block with its defaults: a 3-bit quadword index and one non-interleaved low bit in paired mode. With these values the full eight-beat block is reachable in both orderings. It covers critical indices at zero, in the middle and at the top, and a paired start with an odd low bit, which shows that bit being overridden. With the same width, stalls on the first, a middle and the last beat are also reachable, as are a start attempt during a burst and back-to-back transfers.

// File: rtl/wrap_seq_pkg.sv
package wrap_seq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture start index and mode, clear beat count
    logic step;   // a beat was accepted, advance the count
  } seqStrobe_t;
endpackage

// File: rtl/wrap_seq_ctrl.sv
module wrap_seq_ctrl
  import wrap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       beatReady,
  input  logic       atLast,
  output seqStrobe_t strobe,
  output logic       startReady,
  output logic       beatValid,
  output logic       done
);
  seqState_t state, stateNext;

  always_comb begin
    startReady  = (state == ST_IDLE);
    beatValid   = (state == ST_SEND);
    strobe.load = startReady && startValid;
    strobe.step = beatValid && beatReady;
    stateNext   = state;
    if (strobe.load) begin
      stateNext = ST_SEND;
    end else if (strobe.step && atLast) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.step && atLast;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && atLast) |=> (done && startReady && !beatValid)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_STALL_KEEPS_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> beatValid); // R7
  AST_START_LAUNCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (beatValid && !startReady)); // R9
endmodule

// File: rtl/wrap_seq_dp.sv
module wrap_seq_dp
  import wrap_seq_pkg::*;
#(
  parameter int QW_W   = 3,
  parameter int PAIR_W = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [QW_W-1:0] startIdx,
  input  logic            startDouble,
  output logic [QW_W-1:0] beatIdx,
  output logic            atFirst,
  output logic            atLast
);
  logic [QW_W-1:0] baseIdx;
  logic [QW_W-1:0] beatCnt;
  logic            dblMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseIdx <= '0;
      beatCnt <= '0;
      dblMode <= 1'b0;
    end else if (strobe.load) begin
      baseIdx <= startIdx;
      beatCnt <= '0;
      dblMode <= startDouble;
    end else if (strobe.step) begin
      beatCnt <= beatCnt + QW_W'(1);
    end
  end

  // per-bit order: low bits walk linearly in paired mode, others interleave
  for (genvar i = 0; i < QW_W; i++) begin : g_bit
    if (i < PAIR_W) begin : g_pairLow
      assign beatIdx[i] = dblMode ? beatCnt[i] : (beatCnt[i] ^ baseIdx[i]);
    end else begin : g_inter
      assign beatIdx[i] = beatCnt[i] ^ baseIdx[i];
    end
  end

  assign atFirst = (beatCnt == '0);
  assign atLast  = &beatCnt;

  AST_CRITICAL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !startDouble) |=> (beatIdx == $past(startIdx))); // R2
  AST_PAIR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && startDouble) |=> (beatIdx[PAIR_W-1:0] == '0)); // R4
  AST_STEP_LEAVES_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !atLast && !strobe.load) |=> !atFirst); // R5
  AST_IDLE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(beatIdx)); // R7
endmodule

// File: rtl/qw_wrap_sequencer.sv
module qw_wrap_sequencer
  import wrap_seq_pkg::*;
#(
  parameter int QW_W   = 3,
  parameter int PAIR_W = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  output logic            startReady,
  input  logic [QW_W-1:0] startIdx,
  input  logic            startDouble,
  output logic            beatValid,
  input  logic            beatReady,
  output logic [QW_W-1:0] beatIdx,
  output logic            beatFirst,
  output logic            beatLast,
  output logic            done
);
  localparam int BEATS = 1 << QW_W;

  seqStrobe_t strobe;
  logic       atFirst;
  logic       atLast;

  wrap_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .beatReady  (beatReady),
    .atLast     (atLast),
    .strobe     (strobe),
    .startReady (startReady),
    .beatValid  (beatValid),
    .done       (done)
  );

  wrap_seq_dp #(.QW_W(QW_W), .PAIR_W(PAIR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startIdx    (startIdx),
    .startDouble (startDouble),
    .beatIdx     (beatIdx),
    .atFirst     (atFirst),
    .atLast      (atLast)
  );

  assign beatFirst = beatValid && atFirst;
  assign beatLast  = beatValid && atLast;

  initial begin
    AST_ENOUGH_BEATS: assert (BEATS >= 2 && PAIR_W < QW_W); // R5
  end

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> ($stable(beatIdx) && $stable(beatFirst) && $stable(beatLast))); // R7
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> !startReady); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({beatFirst, beatLast})); // R5
endmodule

// File: tb/qw_wrap_sequencer_bench.sv
module qw_wrap_sequencer_bench;
  localparam time CLK_P = 20ns;
  localparam int  NVEC  = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic       startReady;
  logic [2:0] startIdx = '0;
  logic       startDouble = 1'b0;
  logic       beatValid;
  logic       beatReady = 1'b1;
  logic [2:0] beatIdx;
  logic       beatFirst;
  logic       beatLast;
  logic       done;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  qw_wrap_sequencer u_qw_wrap_sequencer (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startReady(startReady),
    .startIdx(startIdx), .startDouble(startDouble),
    .beatValid(beatValid), .beatReady(beatReady),
    .beatIdx(beatIdx), .beatFirst(beatFirst), .beatLast(beatLast),
    .done(done)
  );

  // stimulus (mode, critical index) and the expected index order
  localparam logic       VEC_DBL   [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [2:0] VEC_START [NVEC] = '{3'd2, 3'd5, 3'd0, 3'd5, 3'd3, 3'd7};
  localparam logic [2:0] VEC_EXP [NVEC][8] = '{
    '{3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5},
    '{3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2},
    '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
    '{3'd4, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3},
    '{3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5},
    '{3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one full transfer; stallMask bit k stalls one cycle before beat k
  task automatic runXfer(input logic dbl, input logic [2:0] st, input int v,
                         input logic [7:0] stallMask, input bit pokeStart);
    @(negedge clk);
    check(startReady == 1'b1, "R9 ready before start", startReady, 1);
    startValid = 1'b1; startIdx = st; startDouble = dbl;
    @(negedge clk);
    startValid = 1'b0; startIdx = ~st; startDouble = ~dbl;
    check(beatValid == 1'b1, "R9 valid after start", beatValid, 1);
    for (int k = 0; k < 8; k++) begin
      if (stallMask[k]) begin
        logic [2:0] held;
        held = beatIdx;
        beatReady = 1'b0;
        @(negedge clk);
        check(beatIdx == held && beatValid, "R7 stall holds index", beatIdx, held);
        check(beatFirst == (k == 0) && beatLast == (k == 7), "R7 stall holds flags",
              {beatFirst, beatLast}, {k == 0, k == 7});
        beatReady = 1'b1;
      end
      if (pokeStart && k == 3) begin
        startValid = 1'b1; startIdx = 3'd1; startDouble = 1'b0;
        check(startReady == 1'b0, "R6 busy refuses start", startReady, 0);
      end
      if (dbl) begin
        check(beatIdx == VEC_EXP[v][k], "R3 paired order", beatIdx, VEC_EXP[v][k]);
        check(beatIdx[0] == k[0], "R4 paired low bit", beatIdx[0], k[0]);
      end else begin
        check(beatIdx == VEC_EXP[v][k], "R2 single order", beatIdx, VEC_EXP[v][k]);
      end
      check(beatFirst == (k == 0), "R5 first flag", beatFirst, k == 0);
      check(beatLast == (k == 7), "R5 last flag", beatLast, k == 7);
      check(done == 1'b0, "R8 no early done", done, 0);
      @(negedge clk);
      startValid = 1'b0;
    end
    check(done == 1'b1, "R8 done after last", done, 1);
    check(beatValid == 1'b0, "R5 eight beats only", beatValid, 0);
    check(startReady == 1'b1, "R8 ready with done", startReady, 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(startReady == 1'b1, "R1 reset startReady", startReady, 1);
    check(beatValid == 1'b0, "R1 reset beatValid", beatValid, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(beatValid == 1'b0, "R1 idle after reset", beatValid, 0);

    for (int v = 0; v < NVEC; v++) begin
      runXfer(VEC_DBL[v], VEC_START[v], v, 8'h00, 1'b0);
    end

    // corner cases: stalls on first, middle, last beats; start during burst
    runXfer(1'b0, 3'd2, 0, 8'b1000_0101, 1'b0);
    runXfer(1'b1, 3'd5, 3, 8'b1000_0001, 1'b1);
    runXfer(1'b0, 3'd5, 1, 8'h00, 1'b1);

    // back-to-back transfer right after done
    runXfer(1'b1, 3'd7, 5, 8'h10, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule